// File: doc/BRIEF.md
# Frequency Hop Sequencer

This block paces the channel changes of a frequency-hopping radio link. A start strobe opens a transmission or reception on channel 0. While the packet is still in its preamble and header, the link stays on channel 0 and no time is counted. Once the payload begins, a cycle timer measures hop periods of a programmable length. At the end of each period the present-channel index steps forward, wrapping after a programmable last channel, and an interrupt line goes high to ask host software for the next frequency.

The host loads the frequency word for the coming hop through a write port at any time during the current period. At the hop the loaded word moves to the frequency output that drives the synthesizer. If no word was loaded in time, the old frequency stays in place and a sticky late-programming flag goes high. The host clears the interrupt by writing a one to its status bit.

Top module: `hop_sequencer`

## Requirements
- R1: After reset the channel index is 0, the interrupt is low, the frequency output is 0 and the late flag is low.
- R2: A start strobe sets the channel index to 0, clears the interrupt and the late flag, restarts the hop timer and leaves the frequency output unchanged. It takes priority over every other input in the same cycle.
- R3: While hdr_phase_i is 1 (preamble/header), no hop occurs and the hop timer is held at zero, so a following payload needs a full period before its first hop.
- R4: With hdr_phase_i at 0 after a start, a hop occurs on every hop_period_i-th payload cycle; a period of 0 or 1 hops on every cycle. Each hop adds one to the channel index.
- R5: A hop taken when the channel index is at or above max_chan_i returns the index to 0.
- R6: Every hop sets irq_o to 1.
- R7: A clear write with irq_clr_bit_i at 1 lowers irq_o on the next cycle; with the bit at 0 it has no effect; a hop in the same cycle leaves irq_o at 1.
- R8: A frequency word written before a hop is driven on freq_o from that hop on; a word written in the hop cycle itself waits for the following hop.
- R9: A hop with no word loaded keeps freq_o and sets late_err_o, which stays high until a reset or start.
- R10: Before the first start after reset, no hop occurs whatever the phase input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Transmission/reception start strobe |
| hdr_phase_i | input | 1 | 1 during preamble/header, 0 during payload |
| hop_period_i | input | PW (16) | Hop period in clock cycles |
| max_chan_i | input | CW (6) | Highest channel index before wrap |
| freq_wr_i | input | 1 | Write strobe for the next frequency word |
| freq_wdata_i | input | FW (24) | Next frequency word |
| irq_clr_wr_i | input | 1 | Interrupt status write strobe |
| irq_clr_bit_i | input | 1 | Status bit value written; 1 clears |
| chan_o | output | CW (6) | Present channel index |
| irq_o | output | 1 | Change-channel interrupt |
| freq_o | output | FW (24) | Frequency word applied at the last hop |
| late_err_o | output | 1 | Sticky late-programming error |

## Verification
On every cycle the assertions check that a start zeroes the index and flags, that the header phase freezes the index, that every index change is accompanied by the interrupt, that the wrap happens at the last channel, that the clear and set priorities of the interrupt hold, that the frequency output only moves at a hop and that the late flag stays set. The exact hop spacing for each period, the full wrap sequence over many hops, the timer restart after a header and which written word reaches the output can only be shown by the bench, which sweeps small periods and channel counts and computes the expected index arithmetically.

// File: rtl/hop_pkg.sv
// Shared definitions for the hop sequencer.
// Assumes: defaults are sized for a small radio channel plan.
package hop_pkg;
    localparam int DEF_PW = 16;
    localparam int DEF_CW = 6;
    localparam int DEF_FW = 24;

    // Sequencer run state: idle until the first start strobe.
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;
endpackage

// File: rtl/hop_timer.sv
// Hop period timer. Counts payload cycles and emits a one-cycle hop
// pulse at the end of each period. Held at zero during the header
// phase, restarted by start, silent until the first start.
// Assumes: period values 0 and 1 both mean a hop every payload cycle.
module hop_timer
    import hop_pkg::*;
#(
    parameter int PW = DEF_PW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          hdr_phase_i,
    input  logic [PW-1:0] period_i,
    output logic          hop_o
);
    localparam int XW = PW + 1;

    seq_state_t    state_q;
    logic [PW-1:0] cnt_q;
    logic          run_w;
    logic [XW-1:0] cnt_next_w;

    // Timer runs only in payload, after a start, and not in a start cycle.
    always_comb begin
        run_w      = (state_q == SEQ_RUN) && !hdr_phase_i && !start_i;
        cnt_next_w = {1'b0, cnt_q} + XW'(1);
        hop_o      = run_w && (cnt_next_w >= {1'b0, period_i});
    end

    // Run state: entered on the first start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       state_q <= SEQ_IDLE;
        else if (start_i) state_q <= SEQ_RUN;
    end

    // Cycle counter: cleared on start, header, or hop; else counts.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (!run_w || hop_o) cnt_q <= '0;
        else                     cnt_q <= cnt_q + PW'(1);
    end
endmodule

// File: rtl/hop_chan_ctr.sv
// Present-channel counter. Starts at 0, steps by one at each hop and
// wraps to 0 after the programmed last channel.
// Assumes: hop never coincides with start (timer gates it).
module hop_chan_ctr
    import hop_pkg::*;
#(
    parameter int CW = DEF_CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          hop_i,
    input  logic [CW-1:0] max_chan_i,
    output logic [CW-1:0] chan_o
);
    // Channel index update with wrap at or above the last channel.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i)         chan_o <= '0;
        else if (hop_i) begin
            if (chan_o >= max_chan_i)  chan_o <= '0;
            else                       chan_o <= chan_o + CW'(1);
        end
    end
endmodule

// File: rtl/hop_freq_reg.sv
// Next-frequency staging. Holds the host's word until the next hop,
// then moves it to the output; a hop with nothing staged keeps the old
// word and sets a sticky late flag.
// Assumes: a write in the hop cycle is staged for the following hop.
module hop_freq_reg
    import hop_pkg::*;
#(
    parameter int FW = DEF_FW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          hop_i,
    input  logic          wr_i,
    input  logic [FW-1:0] wdata_i,
    output logic [FW-1:0] freq_o,
    output logic          late_o
);
    logic [FW-1:0] stage_q;
    logic          staged_q;

    // Staging register: a write (re)fills it, a hop empties it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q  <= '0;
            staged_q <= 1'b0;
        end else if (wr_i) begin
            stage_q  <= wdata_i;
            staged_q <= 1'b1;
        end else if (hop_i) begin
            staged_q <= 1'b0;
        end
    end

    // Applied word: takes the staged word at a hop if one is ready.
    always_ff @(posedge clk) begin
        if (!rst_n)                  freq_o <= '0;
        else if (hop_i && staged_q)  freq_o <= stage_q;
    end

    // Late flag: sticky until reset or start.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i)        late_o <= 1'b0;
        else if (hop_i && !staged_q)  late_o <= 1'b1;
    end
endmodule

// File: rtl/hop_sequencer.sv
// Frequency hop sequencer top. Ties the period timer, channel counter
// and frequency staging together and owns the change-channel interrupt
// (set at each hop, cleared by writing a one, set wins over clear).
// Assumes: period and last-channel inputs are static during a packet.
module hop_sequencer
    import hop_pkg::*;
#(
    parameter int PW = DEF_PW,
    parameter int CW = DEF_CW,
    parameter int FW = DEF_FW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          hdr_phase_i,
    input  logic [PW-1:0] hop_period_i,
    input  logic [CW-1:0] max_chan_i,
    input  logic          freq_wr_i,
    input  logic [FW-1:0] freq_wdata_i,
    input  logic          irq_clr_wr_i,
    input  logic          irq_clr_bit_i,
    output logic [CW-1:0] chan_o,
    output logic          irq_o,
    output logic [FW-1:0] freq_o,
    output logic          late_err_o
);
    logic hop_w;

    hop_timer #(.PW(PW)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .hdr_phase_i (hdr_phase_i),
        .period_i    (hop_period_i),
        .hop_o       (hop_w)
    );

    hop_chan_ctr #(.CW(CW)) u_chan (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .hop_i      (hop_w),
        .max_chan_i (max_chan_i),
        .chan_o     (chan_o)
    );

    hop_freq_reg #(.FW(FW)) u_freq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .hop_i   (hop_w),
        .wr_i    (freq_wr_i),
        .wdata_i (freq_wdata_i),
        .freq_o  (freq_o),
        .late_o  (late_err_o)
    );

    // Interrupt flag: start clears, hop sets, write-one clears.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i)                   irq_o <= 1'b0;
        else if (hop_w)                          irq_o <= 1'b1;
        else if (irq_clr_wr_i && irq_clr_bit_i)  irq_o <= 1'b0;
    end
endmodule

// File: rtl/hop_sequencer_chk.sv
// Property checker for hop_sequencer, bound into every instance.
// Assumes: hop is the timer's internal hop pulse.
module hop_sequencer_chk #(
    parameter int CW = 6,
    parameter int FW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          hdr_phase_i,
    input logic [CW-1:0] max_chan_i,
    input logic          irq_clr_wr_i,
    input logic          irq_clr_bit_i,
    input logic [CW-1:0] chan_o,
    input logic          irq_o,
    input logic [FW-1:0] freq_o,
    input logic          late_err_o,
    input logic          hop
);
    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (chan_o == '0) && !irq_o && !late_err_o);

    a_r3_header_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_phase_i && !start_i) |=> $stable(chan_o));

    a_r5_wrap_at_last: assert property (@(posedge clk) disable iff (!rst_n)
        (hop && chan_o >= max_chan_i) |=> (chan_o == '0));

    a_r6_change_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(start_i) && chan_o != $past(chan_o)) |-> irq_o);

    a_r6_hop_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
        hop |=> irq_o);

    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr_wr_i && irq_clr_bit_i && !hop) |=> !irq_o);

    a_r8_freq_moves_at_hop: assert property (@(posedge clk) disable iff (!rst_n)
        !hop |=> $stable(freq_o));

    a_r9_late_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (late_err_o && !start_i) |=> late_err_o);
endmodule

bind hop_sequencer hop_sequencer_chk #(.CW(CW), .FW(FW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .hdr_phase_i   (hdr_phase_i),
    .max_chan_i    (max_chan_i),
    .irq_clr_wr_i  (irq_clr_wr_i),
    .irq_clr_bit_i (irq_clr_bit_i),
    .chan_o        (chan_o),
    .irq_o         (irq_o),
    .freq_o        (freq_o),
    .late_err_o    (late_err_o),
    .hop           (hop_w)
);

// File: tb/hop_sequencer_tb.sv
// Self-checking bench: sweeps small periods and channel counts with
// arithmetic expectations, then directed interrupt/frequency cases.
module hop_sequencer_tb;
    localparam int PW = 16;
    localparam int CW = 6;
    localparam int FW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          hdr_phase_i = 1'b1;
    logic [PW-1:0] hop_period_i = '0;
    logic [CW-1:0] max_chan_i = '0;
    logic          freq_wr_i = 1'b0;
    logic [FW-1:0] freq_wdata_i = '0;
    logic          irq_clr_wr_i = 1'b0;
    logic          irq_clr_bit_i = 1'b0;
    logic [CW-1:0] chan_o;
    logic          irq_o;
    logic [FW-1:0] freq_o;
    logic          late_err_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hop_sequencer #(.PW(PW), .CW(CW), .FW(FW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .hdr_phase_i(hdr_phase_i),
        .hop_period_i(hop_period_i), .max_chan_i(max_chan_i),
        .freq_wr_i(freq_wr_i), .freq_wdata_i(freq_wdata_i),
        .irq_clr_wr_i(irq_clr_wr_i), .irq_clr_bit_i(irq_clr_bit_i),
        .chan_o(chan_o), .irq_o(irq_o), .freq_o(freq_o), .late_err_o(late_err_o)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_start();
        start_i = 1'b1;
        step();
        start_i = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step();
        step();
        rst_n = 1'b1;
        // R1 reset values
        check("R1 chan", 32'(chan_o), 0);
        check("R1 irq", 32'(irq_o), 0);
        check("R1 freq", 32'(freq_o), 0);
        check("R1 late", 32'(late_err_o), 0);

        // R10 no hops before first start
        hdr_phase_i = 1'b0;
        hop_period_i = 16'd1;
        for (int i = 0; i < 6; i++) begin
            step();
            check("R10 chan idle", 32'(chan_o), 0);
            check("R10 irq idle", 32'(irq_o), 0);
        end

        // Sweep: R4 spacing, R5 wrap, R6 irq, R9 late, R3 header
        for (int p = 0; p < 6; p++) begin
            for (int m = 0; m < 4; m++) begin
                if (p == 4 || m == 2) continue;
                begin
                    int pe;
                    int nsteps;
                    pe = (p < 2) ? 1 : p;
                    nsteps = pe * (m + 1) * 2 + 3;
                    hop_period_i = PW'(p);
                    max_chan_i = CW'(m);
                    hdr_phase_i = 1'b1;
                    do_start();
                    check("R2 chan after start", 32'(chan_o), 0);
                    check("R2 irq after start", 32'(irq_o), 0);
                    check("R2 late after start", 32'(late_err_o), 0);
                    for (int h = 0; h < 4; h++) begin
                        step();
                        check("R3 header hold", 32'(chan_o), 0);
                    end
                    hdr_phase_i = 1'b0;
                    for (int n = 1; n <= nsteps; n++) begin
                        step();
                        check("R4 R5 chan", 32'(chan_o), 32'((n / pe) % (m + 1)));
                        check("R6 irq", 32'(irq_o), 32'(n >= pe));
                        check("R9 late", 32'(late_err_o), 32'(n >= pe));
                        check("R9 freq kept", 32'(freq_o), 0);
                    end
                end
            end
        end

        // R7 write-one-to-clear, period 4
        hop_period_i = 16'd4;
        max_chan_i = 6'd7;
        hdr_phase_i = 1'b0;
        do_start();
        for (int n = 1; n <= 4; n++) step();
        check("R6 irq at hop", 32'(irq_o), 1);
        irq_clr_wr_i = 1'b1; irq_clr_bit_i = 1'b0;
        step();
        check("R7 write zero no effect", 32'(irq_o), 1);
        irq_clr_bit_i = 1'b1;
        step();
        check("R7 write one clears", 32'(irq_o), 0);
        irq_clr_wr_i = 1'b0;
        step();
        check("R7 stays clear", 32'(irq_o), 0);
        irq_clr_wr_i = 1'b1;
        step();
        check("R7 hop beats clear", 32'(irq_o), 1);
        check("R4 chan two hops", 32'(chan_o), 2);
        irq_clr_wr_i = 1'b0; irq_clr_bit_i = 1'b0;

        // R8 frequency staging, period 3
        hop_period_i = 16'd3;
        do_start();
        freq_wr_i = 1'b1; freq_wdata_i = 24'h0000A1;
        step();
        freq_wr_i = 1'b0;
        step();
        check("R8 not before hop", 32'(freq_o), 0);
        step();
        check("R8 applied at hop", 32'(freq_o), 32'h0000A1);
        check("R9 no late when loaded", 32'(late_err_o), 0);
        step();
        step();
        freq_wr_i = 1'b1; freq_wdata_i = 24'h0000B2;
        step();
        freq_wr_i = 1'b0;
        check("R8 hop-cycle write waits", 32'(freq_o), 32'h0000A1);
        check("R9 late set", 32'(late_err_o), 1);
        step();
        step();
        check("R9 late sticky", 32'(late_err_o), 1);
        step();
        check("R8 applied next hop", 32'(freq_o), 32'h0000B2);
        check("R4 chan three hops", 32'(chan_o), 3);

        // R2 start mid-run, R3 timer restart after header
        do_start();
        check("R2 chan zero", 32'(chan_o), 0);
        check("R2 irq cleared", 32'(irq_o), 0);
        check("R2 late cleared", 32'(late_err_o), 0);
        check("R2 freq unchanged", 32'(freq_o), 32'h0000B2);
        step();
        step();
        hdr_phase_i = 1'b1;
        for (int i = 0; i < 5; i++) step();
        hdr_phase_i = 1'b0;
        step();
        step();
        check("R3 timer restarted", 32'(chan_o), 0);
        step();
        check("R3 full period after header", 32'(chan_o), 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule